// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the stream of completing instructions and compares each one's effective address against two programmed breakpoint addresses. A two-bit mode field picks how the two addresses combine: a match on the first alone, a match on either, a window strictly between them, or the region strictly outside them. A qualifying hit while the exception enable is set raises a one-cycle debug exception request, and the fixed vector offset 0x01300 is presented with it.

Two watchpoint pins make the matches visible outside the core. In OR signalling each pin follows its own breakpoint address. In AND signalling only the second pin reports, and it reports the combined condition. A quiet bit freezes both pins at their current level. Every pin pulse is stretched by a counter so that it stays high for a whole bus cycle, given as a count of core cycles.

Software programs the registers through three write strobes. A write takes effect at the clock edge, and a completion in the same cycle is compared against the old values.

Top module: `iabp_unit`

## Requirements
- R1: After reset both breakpoint addresses are zero, the mode is 0, all control bits are clear, and `wp0_o`, `wp1_o`, `exc_req` and `exc_vec` are all zero.
- R2: In mode 0 (`ctl_mode`=2'b00) the condition holds when address bits [31:2] of `cmt_ea` equal bits [31:2] of breakpoint 0. Bits [1:0] are ignored everywhere.
- R3: In mode 1 (2'b01) the condition holds when the word address equals breakpoint 0 or breakpoint 1.
- R4: In mode 2 (2'b10) the condition holds when the unsigned word address is strictly above breakpoint 0 and strictly below breakpoint 1. Both ends are excluded.
- R5: In mode 3 (2'b11) the condition holds when the unsigned word address is strictly below breakpoint 0 or strictly above breakpoint 1.
- R6: With `ctl_and`=0, a completion equal to breakpoint 0 triggers `wp0_o`. A completion equal to breakpoint 1 triggers `wp1_o`, but only in modes 1 to 3.
- R7: With `ctl_and`=1, `wp0_o` is never triggered, and `wp1_o` is triggered whenever the mode condition holds.
- R8: While the registered quiet bit (`ctl_quiet`) is 1, no trigger is taken and neither watchpoint pin changes level.
- R9: A trigger at a clock edge drives the pin high from the next cycle for exactly HOLD cycles. A new trigger reloads the full HOLD count.
- R10: A completion with `cmt_valid`=1, a true mode condition and the exception enable set makes `exc_req` high for the following cycle only. `exc_vec` is 0x01300 in that cycle and zero otherwise.
- R11: Nothing triggers while `cmt_valid` is 0. No exception is requested while the enable bit is 0, whatever the signalling mode or the quiet bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmt_valid | input | 1 | An instruction completes this cycle |
| cmt_ea | input | 32 | Effective address of the completing instruction |
| bp0_we | input | 1 | Write `bp_wdata` into breakpoint address 0 |
| bp1_we | input | 1 | Write `bp_wdata` into breakpoint address 1 |
| bp_wdata | input | 32 | Breakpoint address write data |
| ctl_we | input | 1 | Write the control fields below |
| ctl_mode | input | 2 | Match mode 0..3 |
| ctl_and | input | 1 | 1 selects AND signalling, 0 selects OR |
| ctl_quiet | input | 1 | Freeze the watchpoint pins |
| ctl_exc_en | input | 1 | Enable the exception request |
| wp0_o | output | 1 | Watchpoint pin 0 |
| wp1_o | output | 1 | Watchpoint pin 1 |
| exc_req | output | 1 | Debug exception request pulse |
| exc_vec | output | 20 | Vector offset, valid with `exc_req` |

## Verification
Every result is registered once. A completion presented before edge k shows up on `exc_req`, `exc_vec` and on the rising of a pin just after edge k, and a pin then holds for HOLD cycles. A register write at edge k governs the comparisons of completions from edge k+1 on. The bench drives its inputs on the falling edge and advances its reference model once per cycle, in the same order. It compares all four outputs on the next falling edge, so each expected value is sampled in the cycle it is due.

// File: rtl/iabp_pkg.sv
package iabp_pkg;
  typedef enum logic [1:0] {
    MD_EQ0     = 2'b00,
    MD_EITHER  = 2'b01,
    MD_INSIDE  = 2'b10,
    MD_OUTSIDE = 2'b11
  } iabp_mode_e;

  localparam int unsigned VEC_W = 20;
  localparam logic [VEC_W-1:0] IABP_VEC = 20'h01300;

  typedef struct packed {
    iabp_mode_e mode;
    logic       and_sig;
    logic       quiet;
    logic       exc_en;
  } iabp_ctl_t;
endpackage

// File: rtl/iabp_cmp.sv
module iabp_cmp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IGN_W  = 2
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] bp0,
  input  logic [ADDR_W-1:0] bp1,
  input  iabp_pkg::iabp_mode_e mode,
  output logic eq0,
  output logic eq1,
  output logic cond
);
  import iabp_pkg::*;
  localparam int unsigned W_W = ADDR_W - IGN_W;

  function automatic logic [W_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IGN_W];
  endfunction

  function automatic logic mode_hit(input iabp_mode_e m, input logic [W_W-1:0] w,
                                    input logic [W_W-1:0] w0, input logic [W_W-1:0] w1);
    unique case (m)
      MD_EQ0:     return w == w0;
      MD_EITHER:  return (w == w0) || (w == w1);
      MD_INSIDE:  return (w > w0) && (w < w1);
      default:    return (w < w0) || (w > w1);
    endcase
  endfunction

  logic [W_W-1:0] w, w0, w1;
  assign w    = word_of(ea);
  assign w0   = word_of(bp0);
  assign w1   = word_of(bp1);
  assign eq0  = (w == w0);
  assign eq1  = (w == w1);
  assign cond = mode_hit(mode, w, w0, w1);
endmodule

// File: rtl/iabp_stretch.sv
module iabp_stretch #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic freeze,
  output logic pin
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (freeze)       cnt <= cnt;
    else if (trig)         cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign pin = (cnt != '0);

  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !freeze) |=> (cnt == LOAD)) else $error("reload");            // R9
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(pin)) else $error("freeze");                       // R8
  generate
    if (HOLD > 1) begin : g_min
      AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin) |=> pin) else $error("width");                         // R9
    end
  endgenerate
endmodule

// File: rtl/iabp_unit.sv
module iabp_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned HOLD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_valid,
  input  logic [ADDR_W-1:0] cmt_ea,
  input  logic              bp0_we,
  input  logic              bp1_we,
  input  logic [ADDR_W-1:0] bp_wdata,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_and,
  input  logic              ctl_quiet,
  input  logic              ctl_exc_en,
  output logic              wp0_o,
  output logic              wp1_o,
  output logic              exc_req,
  output logic [19:0]       exc_vec
);
  import iabp_pkg::*;
  localparam int unsigned NPIN = 2;

  logic [ADDR_W-1:0] bp0_q, bp1_q;
  iabp_ctl_t         ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp0_q <= '0;
      bp1_q <= '0;
      ctl_q <= '{mode: MD_EQ0, and_sig: 1'b0, quiet: 1'b0, exc_en: 1'b0};
    end else begin
      if (bp0_we) bp0_q <= bp_wdata;
      if (bp1_we) bp1_q <= bp_wdata;
      if (ctl_we) ctl_q <= '{mode: iabp_mode_e'(ctl_mode), and_sig: ctl_and,
                             quiet: ctl_quiet, exc_en: ctl_exc_en};
    end
  end

  logic eq0, eq1, cond;
  iabp_cmp #(.ADDR_W(ADDR_W), .IGN_W(2)) u_cmp (
    .ea(cmt_ea), .bp0(bp0_q), .bp1(bp1_q), .mode(ctl_q.mode),
    .eq0(eq0), .eq1(eq1), .cond(cond)
  );

  // named events for assertions
  logic hit_cond, exc_fire;
  logic [NPIN-1:0] trig, pins;
  assign hit_cond = cmt_valid && cond;
  assign exc_fire = hit_cond && ctl_q.exc_en;
  assign trig[0]  = cmt_valid && !ctl_q.and_sig && eq0;
  assign trig[1]  = cmt_valid && (ctl_q.and_sig ? cond : (eq1 && ctl_q.mode != MD_EQ0));

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      iabp_stretch #(.HOLD(HOLD)) u_str (
        .clk(clk), .rst_n(rst_n), .trig(trig[i]), .freeze(ctl_q.quiet), .pin(pins[i])
      );
    end
  endgenerate

  assign wp0_o = pins[0];
  assign wp1_o = pins[1];

  always_ff @(posedge clk) begin
    if (!rst_n) exc_req <= 1'b0;
    else        exc_req <= exc_fire;
  end
  assign exc_vec = exc_req ? IABP_VEC : '0;

  AST_EXC_NEEDS_CMT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(cmt_valid && ctl_q.exc_en)) else $error("exc src");    // R11
  AST_VEC_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_vec != '0) |-> (exc_req && exc_vec == 20'h01300)) else $error("vec"); // R10
  AST_AND_SILENT0: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.and_sig |-> !trig[0]) else $error("and pin0");                     // R7
  AST_INSIDE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.mode == MD_INSIDE && bp1_q[ADDR_W-1:2] <= bp0_q[ADDR_W-1:2] + 1'b1
     && bp0_q[ADDR_W-1:2] != '1) |-> !cond) else $error("inside");           // R4
  AST_MODE0_NO_PIN1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.and_sig && ctl_q.mode == MD_EQ0) |-> !trig[1]) else $error("m0 pin1"); // R6
  AST_IDLE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |-> (trig == '0 && !exc_fire)) else $error("idle");           // R11
endmodule

// File: tb/tb_iabp_unit.sv
module tb_iabp_unit;
  localparam int HOLD = 4;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmt_valid, bp0_we, bp1_we, ctl_we, ctl_and, ctl_quiet, ctl_exc_en;
  logic [31:0] cmt_ea, bp_wdata;
  logic [1:0] ctl_mode;
  logic wp0_o, wp1_o, exc_req;
  logic [19:0] exc_vec;

  iabp_unit #(.ADDR_W(32), .HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_ea(cmt_ea),
    .bp0_we(bp0_we), .bp1_we(bp1_we), .bp_wdata(bp_wdata), .ctl_we(ctl_we),
    .ctl_mode(ctl_mode), .ctl_and(ctl_and), .ctl_quiet(ctl_quiet),
    .ctl_exc_en(ctl_exc_en), .wp0_o(wp0_o), .wp1_o(wp1_o),
    .exc_req(exc_req), .exc_vec(exc_vec)
  );

  int tests = 0, fails = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_b0, m_b1;
  logic [1:0] m_mode;
  logic m_and, m_quiet, m_en, m_exc;
  int m_c0, m_c1;

  function automatic bit cond_ref(logic [1:0] md, logic [31:0] a, logic [31:0] b0, logic [31:0] b1);
    longint unsigned x = a >> 2, l = b0 >> 2, h = b1 >> 2;
    case (md)
      2'd0: return x == l;
      2'd1: return x == l || x == h;
      2'd2: return l < x && x < h;
      default: return !(l <= x && x <= h);
    endcase
  endfunction

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    m_b0 = 0; m_b1 = 0; m_mode = 0; m_and = 0; m_quiet = 0; m_en = 0; m_exc = 0;
    m_c0 = 0; m_c1 = 0;
  endtask

  // called at negedge with inputs already driven
  task automatic cyc();
    bit t0, t1, c;
    c  = cmt_valid && cond_ref(m_mode, cmt_ea, m_b0, m_b1);
    t0 = cmt_valid && !m_and && (cmt_ea[31:2] == m_b0[31:2]);
    t1 = cmt_valid && (m_and ? c : (m_mode != 0 && cmt_ea[31:2] == m_b1[31:2]));
    if (!m_quiet) begin
      m_c0 = t0 ? HOLD : (m_c0 > 0 ? m_c0 - 1 : 0);
      m_c1 = t1 ? HOLD : (m_c1 > 0 ? m_c1 - 1 : 0);
    end
    m_exc = c && m_en;
    if (bp0_we) m_b0 = bp_wdata;
    if (bp1_we) m_b1 = bp_wdata;
    if (ctl_we) begin m_mode = ctl_mode; m_and = ctl_and; m_quiet = ctl_quiet; m_en = ctl_exc_en; end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " exc_req"}, exc_req, m_exc);
    chk({tag, " exc_vec"}, exc_vec, m_exc ? 32'h01300 : 0);
    chk({tag, " wp0"}, wp0_o, m_c0 > 0);
    chk({tag, " wp1"}, wp1_o, m_c1 > 0);
    cmt_valid = 0; bp0_we = 0; bp1_we = 0; ctl_we = 0;
  endtask

  task automatic set_bp(logic [31:0] a0, logic [31:0] a1);
    bp0_we = 1; bp_wdata = a0; cyc();
    bp1_we = 1; bp_wdata = a1; cyc();
  endtask

  task automatic set_ctl(logic [1:0] md, logic an, logic q, logic en);
    ctl_we = 1; ctl_mode = md; ctl_and = an; ctl_quiet = q; ctl_exc_en = en; cyc();
  endtask

  task automatic run(logic [31:0] a);
    cmt_valid = 1; cmt_ea = a; cyc();
  endtask

  initial begin
    #3000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cmt_valid = 0; cmt_ea = 0; bp0_we = 0; bp1_we = 0; bp_wdata = 0;
    ctl_we = 0; ctl_mode = 0; ctl_and = 0; ctl_quiet = 0; ctl_exc_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    chk("R1 reset exc", exc_req, 0); chk("R1 reset wp0", wp0_o, 0);
    chk("R1 reset wp1", wp1_o, 0); chk("R1 reset vec", exc_vec, 0);
    tag = "R1"; run(32'h0000_0002); // zero registers, mode 0, enable off

    tag = "R2"; set_bp(32'h0000_1000, 32'h0000_2000); set_ctl(2'd0, 0, 0, 1);
    run(32'h0000_1003); run(32'h0000_1004); run(32'h0000_2000);
    tag = "R9"; repeat (HOLD + 1) cyc();
    run(32'h0000_1000); cyc(); run(32'h0000_1001); repeat (HOLD + 1) cyc();

    tag = "R3"; set_ctl(2'd1, 0, 0, 1);
    run(32'h0000_2001); run(32'h0000_1000); run(32'h0000_1800); repeat (HOLD) cyc();
    tag = "R4"; set_ctl(2'd2, 0, 0, 1);
    run(32'h0000_1000); run(32'h0000_1004); run(32'h0000_1FFF); run(32'h0000_2000);
    set_bp(32'h0000_1000, 32'h0000_1004); run(32'h0000_1002); run(32'h0000_1004);
    tag = "R5"; set_bp(32'h0000_1000, 32'h0000_2000); set_ctl(2'd3, 0, 0, 1);
    run(32'h0000_0FFC); run(32'h0000_1000); run(32'h0000_2003); run(32'h0000_2004);
    run(32'h0000_1500); repeat (HOLD) cyc();

    tag = "R6"; set_ctl(2'd1, 0, 0, 0);
    run(32'h0000_1000); run(32'h0000_2000); repeat (HOLD + 1) cyc();
    tag = "R7"; set_ctl(2'd1, 1, 0, 1);
    run(32'h0000_1000); run(32'h0000_2000); repeat (HOLD + 1) cyc();
    set_ctl(2'd2, 1, 0, 0); run(32'h0000_1800); run(32'h0000_3000); repeat (HOLD) cyc();

    tag = "R8"; set_ctl(2'd1, 0, 0, 1); run(32'h0000_1000);
    set_ctl(2'd1, 0, 1, 1); run(32'h0000_2000); run(32'h0000_1000); repeat (HOLD + 2) cyc();
    set_ctl(2'd1, 0, 0, 1); repeat (HOLD + 1) cyc();

    tag = "R11"; set_ctl(2'd1, 0, 0, 1);
    cmt_valid = 0; cmt_ea = 32'h0000_1000; cyc();
    set_ctl(2'd1, 1, 1, 0); run(32'h0000_1000);
    tag = "R10"; set_ctl(2'd0, 0, 0, 1); run(32'h0000_1000); run(32'h0000_1000); cyc();

    tag = "R9";
    for (int i = 0; i < 1500; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel == 0) begin
        ctl_we = 1; ctl_mode = 2'($urandom_range(0, 3)); ctl_and = 1'($urandom_range(0, 1));
        ctl_quiet = ($urandom_range(0, 7) == 0); ctl_exc_en = 1'($urandom_range(0, 1));
      end else if (sel == 1) begin
        if ($urandom_range(0, 1) == 1) bp0_we = 1; else bp1_we = 1;
        bp_wdata = 32'h0000_1000 + 32'($urandom_range(0, 63)) * 4;
      end
      cmt_valid = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: cmt_ea = m_b0 + 32'($urandom_range(0, 3));
        1: cmt_ea = m_b1 + 32'($urandom_range(0, 3));
        2: cmt_ea = m_b0 + 32'($urandom_range(0, 8)) * 4 - 16;
        default: cmt_ea = 32'h0000_0F00 + 32'($urandom_range(0, 1023));
      endcase
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule